// File: doc/BRIEF.md
# Power-Management Event Status and SCI Controller

This block keeps the power-management event state of a chip: a 16-bit event status register, a 16-bit event enable register and a 16-bit general control register, all reached through a small register port. Status bits are set by hardware events and cleared by software writing ones to them. The block drives a level system control interrupt (SCI) for as long as an enabled status bit from a fixed set of four event sources is pending.

A free-running power-management counter advances on each `tick_i` pulse. Each time it crosses a boundary of 2^(TMR_W-1) ticks, the timer-overflow status bit is set. The point it compares against is stored and is moved forward only when software clears a pending timer status bit. A power-button pulse is recorded only when its enable bit is set. A resume indication marks both the wake bit and the power-button bit.

Top module: `pm1_evt_ctrl`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) sets the status, enable and control registers to 0x0000 and holds `sci_o` low.
- R2: Register offsets on `addr_i` are: status 0x0, enable 0x2, control 0x4. A write to enable or control stores `wdata_i`, and a later read returns that value. Every other offset reads 0x0000, and writes to it change no register.
- R3: A write to status clears each status bit whose `wdata_i` bit is 1. Bits written as 0 keep their value.
- R4: Timer status (bit 0) is set when the counter has reached or passed the stored overflow point, whether or not timer enable (bit 0) is set. After reset the first point is 2^(TMR_W-1) ticks. A status read returns bit 0 as 1 in the same cycle that the counter reaches the point.
- R5: When a status write clears timer status while it is pending, the overflow point moves to the next multiple of 2^(TMR_W-1) above the current count. No further timer status appears before that point.
- R6: A `pwrbtn_i` pulse sets status bit 8 only if enable bit 8 is set. Otherwise it leaves the status register unchanged.
- R7: A `resume_i` pulse sets status bit 15 (wake) and status bit 8 (power button).
- R8: `sci_o` is high exactly when status AND enable has any of bits 10, 8, 5 or 0 set. It follows the register values from the edge that updates them. Bit 15 never raises it.
- R9: In one cycle, a status write that clears timer status takes effect over an overflow reached in that cycle, and it re-arms the point. An event pulse takes effect over a clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe, one write per high cycle |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | Counter advance enable |
| pwrbtn_i | input | 1 | Power-button event pulse |
| resume_i | input | 1 | Resume-from-sleep pulse |
| sci_o | output | 1 | System control interrupt, level |

## Verification
Two things can coincide in one cycle: the counter reaching its overflow point, and software clearing timer status. The bench drives the counter with a continuous tick. It issues the clear in exactly the cycle where the status read first shows bit 0 set. It then expects bit 0 to read back as zero with `sci_o` low, and the next overflow to appear exactly 2^(TMR_W-1) ticks later. A similar collision of a power-button pulse with a clear of bit 8 is expected to leave bit 8 set.

// File: rtl/pm1_evt_pkg.sv
package pm1_evt_pkg;
  localparam int REG_W   = 16;
  localparam int OFS_STS = 'h0;
  localparam int OFS_EN  = 'h2;
  localparam int OFS_CTL = 'h4;

  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam int BIT_WAK = 15;

  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << BIT_RTC) | (1 << BIT_PWR) | (1 << BIT_GBL) | (1 << BIT_TMR));

  typedef enum logic [1:0] {SEL_NONE, SEL_STS, SEL_EN, SEL_CTL} reg_sel_e;
endpackage

// File: rtl/pm1_bus_dec.sv
module pm1_bus_dec
  import pm1_evt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFS_STS))      sel_o = SEL_STS;
    else if (addr_i == ADDR_W'(OFS_EN))  sel_o = SEL_EN;
    else if (addr_i == ADDR_W'(OFS_CTL)) sel_o = SEL_CTL;
    else                                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/pm1_ovf_timer.sv
module pm1_ovf_timer #(
  parameter int TMR_W = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rearm_i,
  output logic hit_o
);
  // one epoch bit above the visible counter keeps the compare wrap-safe
  localparam int EXT_W = TMR_W + 1;
  localparam int LOW_W = TMR_W - 1;
  localparam logic [EXT_W-1:0] STEP = EXT_W'(1) << LOW_W;

  logic [EXT_W-1:0] cnt_q, pt_q, diff;
  logic [1:0]       seg;

  assign diff  = cnt_q - pt_q;
  assign hit_o = ~diff[EXT_W-1];
  assign seg   = cnt_q[EXT_W-1:LOW_W] + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pt_q  <= STEP;
    end else begin
      if (tick_i)  cnt_q <= cnt_q + 1'b1;
      if (rearm_i) pt_q  <= {seg, {LOW_W{1'b0}}};
    end
  end
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
  import pm1_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hit_i,
  input  logic             pwrbtn_i,
  input  logic             resume_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] sts_view_o,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] ctl_o,
  output logic             rearm_o
);
  logic [REG_W-1:0] sts_q, en_q, ctl_q, sts_d, clr, set_vec;
  logic             wr_sts;

  assign wr_sts     = wr_i && (sel_i == SEL_STS);
  assign sts_view_o = sts_q | (REG_W'(hit_i) << BIT_TMR);
  assign clr        = wr_sts ? wdata_i : '0;
  assign rearm_o    = wr_sts && wdata_i[BIT_TMR] && sts_view_o[BIT_TMR];

  always_comb begin
    set_vec = '0;
    if (pwrbtn_i && en_q[BIT_PWR]) set_vec[BIT_PWR] = 1'b1;
    if (resume_i) begin
      set_vec[BIT_PWR] = 1'b1;
      set_vec[BIT_WAK] = 1'b1;
    end
  end

  // events are applied after the clear, so they win
  for (genvar g = 0; g < REG_W; g++) begin : g_sts
    assign sts_d[g] = (sts_view_o[g] & ~clr[g]) | set_vec[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (wr_i && sel_i == SEL_EN)  en_q  <= wdata_i;
      if (wr_i && sel_i == SEL_CTL) ctl_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign ctl_o = ctl_q;
endmodule

// File: rtl/pm1_sci_gen.sv
module pm1_sci_gen
  import pm1_evt_pkg::*;
(
  input  logic [REG_W-1:0] sts_i,
  input  logic [REG_W-1:0] en_i,
  output logic             sci_o
);
  assign sci_o = |(sts_i & en_i & SCI_MASK);
endmodule

// File: rtl/pm1_evt_ctrl.sv
module pm1_evt_ctrl
  import pm1_evt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TMR_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              wr_i,
  output logic [15:0]       rdata_o,
  input  logic              tick_i,
  input  logic              pwrbtn_i,
  input  logic              resume_i,
  output logic              sci_o
);
  reg_sel_e         sel;
  logic             tmr_hit_w, rearm;
  logic [REG_W-1:0] sts_w, sts_view, en_w, ctl_w;

  pm1_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  pm1_ovf_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .rearm_i (rearm),
    .hit_o   (tmr_hit_w)
  );

  pm1_evt_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .hit_i      (tmr_hit_w),
    .pwrbtn_i   (pwrbtn_i),
    .resume_i   (resume_i),
    .sts_o      (sts_w),
    .sts_view_o (sts_view),
    .en_o       (en_w),
    .ctl_o      (ctl_w),
    .rearm_o    (rearm)
  );

  pm1_sci_gen u_sci (
    .sts_i (sts_w),
    .en_i  (en_w),
    .sci_o (sci_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STS: rdata_o = sts_view;
      SEL_EN:  rdata_o = en_w;
      SEL_CTL: rdata_o = ctl_w;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pm1_evt_ctrl_chk.sv
module pm1_evt_ctrl_chk
  import pm1_evt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       wdata_i,
  input logic              pwrbtn_i,
  input logic              resume_i,
  input logic              sci_o,
  input logic [15:0]       sts,
  input logic [15:0]       en
);
  logic wr_sts, wr_en;
  assign wr_sts = wr_i && addr_i == ADDR_W'(OFS_STS);
  assign wr_en  = wr_i && addr_i == ADDR_W'(OFS_EN);

  // R3
  w1c_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && wdata_i == 16'hffff && !pwrbtn_i && !resume_i) |=> (sts == 16'h0000));

  // R2
  en_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en == $past(wdata_i)));

  // R6
  pwrbtn_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrbtn_i && !en[BIT_PWR] && !resume_i && !wr_i) |=> (sts[BIT_PWR] == $past(sts[BIT_PWR])));

  // R6
  pwrbtn_sci_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrbtn_i && en[BIT_PWR] && !wr_en) |=> sci_o);

  // R7
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i |=> (sts[BIT_WAK] && sts[BIT_PWR]));

  // R8
  sci_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> ((sts & en & SCI_MASK) != 16'h0000));
endmodule

bind pm1_evt_ctrl pm1_evt_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pwrbtn_i (pwrbtn_i),
  .resume_i (resume_i),
  .sci_o    (sci_o),
  .sts      (sts_w),
  .en       (en_w)
);

// File: tb/test_pm1_evt_ctrl.sv
module test_pm1_evt_ctrl;
  localparam int TMR_W = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        wr_i = 1'b0;
  logic [15:0] rdata_o;
  logic        tick_i = 1'b0;
  logic        pwrbtn_i = 1'b0;
  logic        resume_i = 1'b0;
  logic        sci_o;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  pm1_evt_ctrl #(.ADDR_W(4), .TMR_W(TMR_W)) i_pm1_evt_ctrl (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rdata_o,
    .tick_i, .pwrbtn_i, .resume_i, .sci_o
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  a;
    logic [15:0] d;
    logic        w;
    logic        pb;
    logic        rs;
    logic [15:0] es;
    logic [15:0] ee;
    logic        sci;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd6, 4'h0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0}, // R6 ignored
    '{4'd2, 4'h2, 16'h0100, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0100, 1'b0}, // R2
    '{4'd6, 4'h0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0100, 16'h0100, 1'b1}, // R6
    '{4'd3, 4'h0, 16'h0001, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0100, 1'b1}, // R3 zeros kept
    '{4'd3, 4'h0, 16'h0100, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0100, 1'b0}, // R3
    '{4'd7, 4'h0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h8100, 16'h0100, 1'b1}, // R7
    '{4'd8, 4'h2, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h8100, 16'h0000, 1'b0}, // R8
    '{4'd8, 4'h2, 16'h0421, 1'b1, 1'b0, 1'b0, 16'h8100, 16'h0421, 1'b0}, // R8
    '{4'd3, 4'h0, 16'h8000, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0421, 1'b0}, // R3
    '{4'd7, 4'h0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h8100, 16'h0421, 1'b0}, // R7
    '{4'd8, 4'h2, 16'h8000, 1'b1, 1'b0, 1'b0, 16'h8100, 16'h8000, 1'b0}, // R8 wake not a cause
    '{4'd8, 4'h2, 16'h0100, 1'b1, 1'b0, 1'b0, 16'h8100, 16'h0100, 1'b1}, // R8
    '{4'd9, 4'h0, 16'h0100, 1'b1, 1'b1, 1'b0, 16'h8100, 16'h0100, 1'b1}, // R9 event wins
    '{4'd2, 4'h6, 16'hffff, 1'b1, 1'b0, 1'b0, 16'h8100, 16'h0100, 1'b1}, // R2 unmapped write
    '{4'd3, 4'h0, 16'hffff, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0100, 1'b0}  // R3
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    wr_i   = 1'b0;
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic cyc();
    @(posedge clk_i);
    if (tick_i) n++;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    tick_i = 1'b0; wr_i = 1'b0; pwrbtn_i = 1'b0; resume_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    cyc();
    wr_i = 1'b0;
  endtask

  task automatic run_to(input int target);
    while (n < target) cyc();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R1 reset state
    rd(4'h0, v); chk("R1 status", v, 16'h0000);
    rd(4'h2, v); chk("R1 enable", v, 16'h0000);
    rd(4'h4, v); chk("R1 control", v, 16'h0000);
    chk("R1 sci", {15'h0, sci_o}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      addr_i = VEC[i].a; wdata_i = VEC[i].d; wr_i = VEC[i].w;
      pwrbtn_i = VEC[i].pb; resume_i = VEC[i].rs;
      cyc();
      wr_i = 1'b0; pwrbtn_i = 1'b0; resume_i = 1'b0;
      rd(4'h0, v); chk($sformatf("R%0d vec %0d status", VEC[i].req, i), v, VEC[i].es);
      rd(4'h2, v); chk($sformatf("R%0d vec %0d enable", VEC[i].req, i), v, VEC[i].ee);
      chk($sformatf("R%0d vec %0d sci", VEC[i].req, i), {15'h0, sci_o}, {15'h0, VEC[i].sci});
    end

    // R2 control storage and unmapped reads
    wr(4'h4, 16'hbeef);
    rd(4'h4, v); chk("R2 control", v, 16'hbeef);
    rd(4'h6, v); chk("R2 unmapped 6", v, 16'h0000);
    rd(4'h1, v); chk("R2 unmapped 1", v, 16'h0000);

    // timer section
    do_reset();
    tick_i = 1'b1;
    run_to(127);
    rd(4'h0, v); chk("R4 before point", v, 16'h0000);
    cyc();
    rd(4'h0, v); chk("R4 at point", v, 16'h0001);
    cyc();
    chk("R8 timer disabled sci", {15'h0, sci_o}, 16'h0000);
    rd(4'h0, v); chk("R4 held", v, 16'h0001);
    wr(4'h2, 16'h0001);
    chk("R8 timer enabled sci", {15'h0, sci_o}, 16'h0001);
    wr(4'h0, 16'h0001);              // rearm from count 130 -> 256
    rd(4'h0, v); chk("R5 cleared", v, 16'h0000);
    chk("R5 sci low", {15'h0, sci_o}, 16'h0000);
    run_to(255);
    rd(4'h0, v); chk("R5 no early overflow", v, 16'h0000);
    cyc();
    rd(4'h0, v); chk("R5 next point", v, 16'h0001);
    wr(4'h0, 16'h0001);              // collides with overflow at 256
    rd(4'h0, v); chk("R9 clear wins", v, 16'h0000);
    chk("R9 sci low", {15'h0, sci_o}, 16'h0000);
    run_to(383);
    rd(4'h0, v); chk("R9 rearmed not yet", v, 16'h0000);
    cyc();
    rd(4'h0, v); chk("R9 rearmed point", v, 16'h0001);
    cyc();
    chk("R8 timer sci", {15'h0, sci_o}, 16'h0001);

    // R1 asynchronous reset mid-run
    wr(4'h4, 16'h1234);
    rst_ni = 1'b0;
    #1;
    chk("R1 async sci", {15'h0, sci_o}, 16'h0000);
    rd(4'h0, v); chk("R1 async status", v, 16'h0000);
    rd(4'h2, v); chk("R1 async enable", v, 16'h0000);
    rd(4'h4, v); chk("R1 async control", v, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule